// File: doc/BRIEF.md
# Negate-Select Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a configurable data width (32 bits by default). It takes two operands and a 3-bit operation code, and it returns a result word together with a Zero flag. The Zero flag is meant for an equality branch: subtracting one operand from the other and testing Zero tells whether they are equal.

The operation code is decoded as two independent fields rather than as a list of opcodes. Bit 2 is the operand-B negate control. It inverts operand B and also supplies the carry-in of a single shared adder, so the same adder produces both A+B and A−B. Bits 1:0 pick one of four results: the bitwise AND, the bitwise OR, the adder output, or the less-than bit. The less-than bit is the sign of the adder output corrected by the adder's signed overflow. With negate set, this bit is a signed A<B comparison. Codes that are not part of the main operation set still decode through the same two fields, so every code gives a defined result.

The block has no clock, no reset and no state. Its outputs follow its inputs within the same cycle, and it is placed between the operand registers and the write-back of a single-cycle datapath.

Top module: `alu_negsel`

## Requirements
- R1: Code 3'b000 gives result = A AND B, bit by bit.
- R2: Code 3'b001 gives result = A OR B, bit by bit.
- R3: Code 3'b010 gives result = (A + B) mod 2^W.
- R4: Code 3'b110 gives result = (A − B) mod 2^W, formed as A + ~B + 1.
- R5: Code 3'b111 gives result = 1 when A < B as signed two's-complement numbers, and 0 otherwise. All bits above bit 0 are always zero. The comparison is also correct when A − B overflows.
- R6: zero_o is 1 exactly when every bit of result_o is 0, for every code.
- R7: The remaining codes use the same field decoding, with bit 2 inverting B and bits 1:0 selecting the result. Code 3'b100 gives A AND NOT B. Code 3'b101 gives A OR NOT B. Code 3'b011 gives 1 in bit 0 when the exact signed sum A+B is negative, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W (32) | Operand A |
| b_i | input | W (32) | Operand B |
| ctrl_i | input | 3 | Operation code: bit 2 negates B and sets the carry-in; bits 1:0 select AND, OR, sum or less-than |
| result_o | output | W (32) | Selected result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
Random operands are drawn over all eight codes. This shows whether the field decoding is right: a wrong negate wiring or a swapped select leg changes most random results. A second set of operands is drawn from a pool of corner values: zero, one, all ones, the most positive value and the most negative value. These separate a comparison that uses the raw subtraction sign from one that applies the overflow correction, and they expose a missing carry-in at the wrap-around points. Pairs with equal operands force the subtraction to exactly zero, which checks that the Zero flag follows the full result and not only some of its bits.

// File: rtl/alu_negsel_pkg.sv
`timescale 1ns/1ps
package alu_negsel_pkg;

    // Result selector carried in the low two bits of the operation code.
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } alu_sel_e;

    // Operation code split into its two fields.
    typedef struct packed {
        logic     bneg;
        alu_sel_e sel;
    } alu_ctrl_t;

    localparam int CTRL_W = 3;

endpackage

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
module alu_logic_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] bx_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o
);
    // One slice per bit, both gates fed by the conditionally inverted B.
    for (genvar i = 0; i < W; i++) begin : g_slice
        assign and_o[i] = a_i[i] & bx_i[i];
        assign or_o[i]  = a_i[i] | bx_i[i];
    end
endmodule

// File: rtl/alu_adder.sv
`timescale 1ns/1ps
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] bx_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    localparam int LOW_W = W - 1;

    logic         c_msb_in;
    logic         c_out;
    logic [LOW_W-1:0] low_sum;

    // Carry into the sign position, from the low W-1 bits alone.
    assign {c_msb_in, low_sum} = {1'b0, a_i[LOW_W-1:0]} + {1'b0, bx_i[LOW_W-1:0]}
                                 + {{LOW_W{1'b0}}, cin_i};
    // Full-width sum with its carry-out.
    assign {c_out, sum_o} = {1'b0, a_i} + {1'b0, bx_i} + {{W{1'b0}}, cin_i};

    // Signed overflow: carry into and out of the sign bit disagree.
    assign ovf_o = c_msb_in ^ c_out;

    always_comb begin
        assert_low_bits_R3: assert (low_sum == sum_o[LOW_W-1:0])
            else $error("adder low part disagrees with full sum");
    end
endmodule

// File: rtl/alu_less_unit.sv
`timescale 1ns/1ps
module alu_less_unit #(
    parameter int W = 32
) (
    input  logic [W-1:0] sum_i,
    input  logic         ovf_i,
    output logic [W-1:0] less_o
);
    logic less_bit;

    // Sign of the exact sum: raw sign bit corrected by overflow.
    assign less_bit = sum_i[W-1] ^ ovf_i;
    assign less_o   = {{(W-1){1'b0}}, less_bit};
endmodule

// File: rtl/alu_result_mux.sv
`timescale 1ns/1ps
module alu_result_mux
    import alu_negsel_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_sel_e     sel_i,
    input  logic [W-1:0] and_i,
    input  logic [W-1:0] or_i,
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] less_i,
    output logic [W-1:0] result_o,
    output logic         zero_o
);
    always_comb begin
        unique case (sel_i)
            SEL_AND:  result_o = and_i;
            SEL_OR:   result_o = or_i;
            SEL_SUM:  result_o = sum_i;
            SEL_LESS: result_o = less_i;
            default:  result_o = '0;
        endcase
    end

    assign zero_o = ~|result_o;

    always_comb begin
        assert_slt_upper_R5: assert (sel_i != SEL_LESS || result_o[W-1:1] == '0)
            else $error("less-than result has upper bits set");
    end
endmodule

// File: rtl/alu_negsel.sv
`timescale 1ns/1ps
module alu_negsel
    import alu_negsel_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic [W-1:0]      result_o,
    output logic              zero_o
);
    alu_ctrl_t    ctrl;
    logic [W-1:0] bx;
    logic [W-1:0] and_v, or_v, sum_v, less_v;
    logic         ovf;

    assign ctrl = alu_ctrl_t'(ctrl_i);
    // Bit 2 inverts B for every leg; it is also the adder carry-in.
    assign bx   = ctrl.bneg ? ~b_i : b_i;

    alu_logic_unit #(.W(W)) u_logic (
        .a_i (a_i), .bx_i (bx), .and_o (and_v), .or_o (or_v)
    );

    alu_adder #(.W(W)) u_adder (
        .a_i (a_i), .bx_i (bx), .cin_i (ctrl.bneg), .sum_o (sum_v), .ovf_o (ovf)
    );

    alu_less_unit #(.W(W)) u_less (
        .sum_i (sum_v), .ovf_i (ovf), .less_o (less_v)
    );

    alu_result_mux #(.W(W)) u_mux (
        .sel_i (ctrl.sel), .and_i (and_v), .or_i (or_v), .sum_i (sum_v),
        .less_i (less_v), .result_o (result_o), .zero_o (zero_o)
    );

    always_comb begin
        assert_and_R1: assert (ctrl_i != 3'b000 || result_o == (a_i & b_i))
            else $error("AND result wrong");
        assert_or_R2: assert (ctrl_i != 3'b001 || result_o == (a_i | b_i))
            else $error("OR result wrong");
        assert_add_R3: assert (ctrl_i != 3'b010 || result_o == a_i + b_i)
            else $error("add result wrong");
        assert_sub_R4: assert (ctrl_i != 3'b110 || result_o == a_i - b_i)
            else $error("subtract result wrong");
        assert_slt_R5: assert (ctrl_i != 3'b111 || result_o[0] == ($signed(a_i) < $signed(b_i)))
            else $error("signed less-than wrong");
        assert_zero_R6: assert (!zero_o || result_o == '0)
            else $error("zero flag set with nonzero result");
        assert_eq_sub_R6: assert (ctrl_i != 3'b110 || zero_o == (a_i == b_i))
            else $error("zero flag does not track equality on subtract");
        assert_andn_R7: assert (ctrl_i != 3'b100 || result_o == (a_i & ~b_i))
            else $error("AND-NOT result wrong");
    end
endmodule

// File: tb/alu_negsel_tb.sv
`timescale 1ns/1ps
module alu_negsel_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic [2:0]   ctrl;
    logic [W-1:0] result;
    logic         zero;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    alu_negsel #(.W(W)) u_dut (
        .a_i (a), .b_i (b), .ctrl_i (ctrl), .result_o (result), .zero_o (zero)
    );

    // Behavioural model written from the requirements.
    function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [2:0] c);
        logic signed [W:0] ext;
        case (c)
            3'b000: return x & y;
            3'b001: return x | y;
            3'b010: return x + y;
            3'b110: return x - y;
            3'b111: return {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
            3'b100: return x & ~y;
            3'b101: return x | ~y;
            default: begin
                ext = $signed({x[W-1], x}) + $signed({y[W-1], y});
                return {{(W-1){1'b0}}, ext[W]};
            end
        endcase
    endfunction

    function automatic string tag(input logic [2:0] c);
        case (c)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b110: return "R4";
            3'b111: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c);
        logic [W-1:0] exp_r;
        @(negedge clk);
        a = x; b = y; ctrl = c;
        #1;
        exp_r = model(x, y, c);
        n_tests++;
        if (result !== exp_r) begin
            n_fail++;
            $display("FAIL %s code=%b a=%h b=%h result=%h expected=%h",
                     tag(c), c, x, y, result, exp_r);
        end
        n_tests++;
        if (zero !== (exp_r == '0)) begin
            n_fail++;
            $display("FAIL R6 code=%b a=%h b=%h zero=%b expected=%b",
                     c, x, y, zero, (exp_r == '0));
        end
    endtask

    function automatic logic [W-1:0] corner(input int unsigned k);
        case (k % 6)
            0: return '0;
            1: return {{(W-1){1'b0}}, 1'b1};
            2: return '1;
            3: return {1'b0, {(W-1){1'b1}}};
            4: return {1'b1, {(W-1){1'b0}}};
            default: return $urandom();
        endcase
    endfunction

    initial begin
        logic [W-1:0] x, y;
        a = '0; b = '0; ctrl = 3'b000;
        void'($urandom(32'h1C0FFEE));
        @(negedge clk); #1;
        // Idle-input state: AND of zeros is zero, flag set (R1, R6).
        n_tests++;
        if (result !== '0 || zero !== 1'b1) begin
            n_fail++;
            $display("FAIL R6 initial result=%h zero=%b expected=0 1", result, zero);
        end

        // Directed corners.
        apply(32'hF0F0_00FF, 32'h0FF0_0F0F, 3'b000);                  // R1
        apply(32'hF0F0_00FF, 32'h0FF0_0F0F, 3'b001);                  // R2
        apply(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);                  // R3 wrap to zero
        apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);                  // R3
        apply(32'h1234_5678, 32'h1234_5678, 3'b110);                  // R4 equal, zero flag
        apply(32'h0000_0000, 32'h0000_0001, 3'b110);                  // R4 borrow
        apply(32'h8000_0000, 32'h0000_0001, 3'b111);                  // R5 overflowing compare -> 1
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b111);                  // R5 overflowing compare -> 0
        apply(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);                  // R5 -1 < 0
        apply(32'h0000_0005, 32'h0000_0005, 3'b111);                  // R5 equal -> 0, zero set
        apply(32'hFFFF_0000, 32'h0F0F_0F0F, 3'b100);                  // R7 and-not
        apply(32'h0000_0000, 32'hFFFF_FFFF, 3'b101);                  // R7 or-not gives zero
        apply(32'h7FFF_FFFF, 32'h0000_0001, 3'b011);                  // R7 sum sign corrected -> 0
        apply(32'h8000_0000, 32'hFFFF_FFFF, 3'b011);                  // R7 negative sum -> 1

        // Random and corner-pool stimulus over all codes.
        for (int i = 0; i < 3000; i++) begin
            case ($urandom() % 4)
                0: begin x = corner($urandom()); y = corner($urandom()); end
                1: begin x = $urandom(); y = x; end
                default: begin x = $urandom(); y = $urandom(); end
            endcase
            apply(x, y, 3'($urandom()));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired result=%h expected=completion", result);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule